// File: doc/BRIEF.md
# UART Task and Event Control Registers

This block is the software-visible control face of a simple serial port. Software drives the port by writing "task" words (start or halt a direction, or suspend both) and learns what happened from single-bit "event" words (byte received, byte sent, line error, receiver halted). There is no status register to poll. A four-bit interrupt mask selects which events reach one level interrupt line. The mask can be written whole, or have bits set or cleared through two alias words.

The port stays inert until a fixed key value is written to its enable word. While it is off, every bus write except one to the enable word is dropped, and every read returns zero. Turning the port off also halts both directions and raises the receiver-halted event. The transmit side is a one-byte hand-off to an external shifter: the byte is accepted only when transmit is running and nothing is outstanding, and the shifter's done pulse turns into the byte-sent event. The receive side reports a byte through a ready pulse. A line-break input latches into a write-one-to-clear error-source word. The baud word and the pin-routing words are plain storage with fixed reset values.

Top module: `uart_te_top`

## Requirements
- R1: Writing 4 to the enable word (word offset 20) turns the port on, writing 0 turns it off, and any other value leaves the on/off state unchanged. Reading the enable word while the port is on returns 4.
- R2: Writing 0 to the enable word halts transmit and receive and sets the receiver-halted event, whether or not the port was on.
- R3: While the port is off, writes to any word other than the enable word have no effect, and every read returns 0.
- R4: The mask (offset 16) is replaced by a write to it. A write to the set alias (offset 17) ORs the value into it, and a write to the clear alias (offset 18) clears the bits that are 1 in the value. Reads of any of the three words return the mask. Mask bit 0 is receive-ready, bit 1 transmit-ready, bit 2 error and bit 3 receiver-halted.
- R5: `irq` is high exactly when some event flag is set and its mask bit is 1. It follows a register change in the cycle after the clock edge that made it.
- R6: Start-receive (offset 0) and start-transmit (offset 2) take effect only when the written value is exactly 1.
- R7: Writing 1 to stop-transmit (offset 3) halts only transmit. Writing 1 to stop-receive (offset 1) halts only receive and sets receiver-halted. Writing 1 to suspend (offset 4) halts both and sets receiver-halted. Other values have no effect.
- R8: A write to transmit data (offset 21) is accepted only while transmit is running and no byte is pending. An accepted byte appears on `txByte` with `txValid` high. A `txDone` pulse while a byte is pending drops `txValid` and sets the transmit-ready event.
- R9: The error-source word (offset 19) clears the bits written as 1. A `lineBreak` pulse sets its bits 1:0 and the error event.
- R10: The event words (receive-ready 8, transmit-ready 9, error 10, receiver-halted 11) read 1 or 0. A write stores whether the value was nonzero, except that receive-ready changes from software only on a write of 0. An `rxReady` pulse sets receive-ready.
- R11: After reset the port is off with both directions halted, the mask, events and error source are 0, the pin-routing words (offset 32 upward) are all ones, and the baud word (offset 24) is 0x04000000.
- R12: Read data is registered and appears in the cycle after `busRdEn`. Unmapped offsets and task words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Word offset |
| busWrEn | input | 1 | Single-cycle write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read request |
| busRdData | output | 32 | Read data, one cycle after the request |
| txByte | output | 8 | Byte handed to the transmit shifter |
| txValid | output | 1 | A byte is pending for the shifter |
| txDone | input | 1 | Shifter has finished the pending byte |
| txStarted | output | 1 | Transmit direction running |
| rxStarted | output | 1 | Receive direction running |
| rxReady | input | 1 | Receive path delivered a byte |
| lineBreak | input | 1 | Receive path saw a line break |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with ADDR_W set to 6 and four pin-routing words. The narrow address puts the last pin word and a truly unmapped offset (63) within one compact word space. Four pin words let the reset value be read back from every one of them. With the default baud reset value, the bench can tell a read that was suppressed because the port is off (zero) from a live read of the baud word.

// File: rtl/uart_te_pkg.sv
package uart_te_pkg;

  // Word offsets of the register file
  localparam int OFS_STARTRX  = 0;
  localparam int OFS_STOPRX   = 1;
  localparam int OFS_STARTTX  = 2;
  localparam int OFS_STOPTX   = 3;
  localparam int OFS_SUSPEND  = 4;
  localparam int OFS_EV_RXRDY = 8;
  localparam int OFS_EV_TXRDY = 9;
  localparam int OFS_EV_ERR   = 10;
  localparam int OFS_EV_RXTO  = 11;
  localparam int OFS_MASK     = 16;
  localparam int OFS_MASKSET  = 17;
  localparam int OFS_MASKCLR  = 18;
  localparam int OFS_ERRSRC   = 19;
  localparam int OFS_ENABLE   = 20;
  localparam int OFS_TXDATA   = 21;
  localparam int OFS_BAUD     = 24;
  localparam int OFS_PIN0     = 32;

  localparam logic [31:0] ENABLE_KEY = 32'd4;

  // Mask bit positions
  localparam int MB_RXRDY = 0;
  localparam int MB_TXRDY = 1;
  localparam int MB_ERR   = 2;
  localparam int MB_RXTO  = 3;
  localparam int MASK_W   = 4;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic wrMask;
    logic wrMaskSet;
    logic wrMaskClr;
    logic wrEvRx;
    logic wrEvTx;
    logic wrEvErr;
    logic wrEvTo;
    logic wrErrSrc;
    logic wrTxData;
    logic wrPin;
    logic wrBaud;
    logic setRxTo;
    logic txFinish;
  } ctlStrobes_t;

endpackage

// File: rtl/uart_te_ctrl.sv
module uart_te_ctrl
  import uart_te_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_PIN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              txDone,
  output ctlStrobes_t       strb,
  output logic              enabled,
  output logic              txStarted,
  output logic              rxStarted,
  output logic              txPending
);

  localparam logic [ADDR_W-1:0] A_STARTRX  = ADDR_W'(OFS_STARTRX);
  localparam logic [ADDR_W-1:0] A_STOPRX   = ADDR_W'(OFS_STOPRX);
  localparam logic [ADDR_W-1:0] A_STARTTX  = ADDR_W'(OFS_STARTTX);
  localparam logic [ADDR_W-1:0] A_STOPTX   = ADDR_W'(OFS_STOPTX);
  localparam logic [ADDR_W-1:0] A_SUSPEND  = ADDR_W'(OFS_SUSPEND);
  localparam logic [ADDR_W-1:0] A_EV_RXRDY = ADDR_W'(OFS_EV_RXRDY);
  localparam logic [ADDR_W-1:0] A_EV_TXRDY = ADDR_W'(OFS_EV_TXRDY);
  localparam logic [ADDR_W-1:0] A_EV_ERR   = ADDR_W'(OFS_EV_ERR);
  localparam logic [ADDR_W-1:0] A_EV_RXTO  = ADDR_W'(OFS_EV_RXTO);
  localparam logic [ADDR_W-1:0] A_MASK     = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_MASKSET  = ADDR_W'(OFS_MASKSET);
  localparam logic [ADDR_W-1:0] A_MASKCLR  = ADDR_W'(OFS_MASKCLR);
  localparam logic [ADDR_W-1:0] A_ERRSRC   = ADDR_W'(OFS_ERRSRC);
  localparam logic [ADDR_W-1:0] A_ENABLE   = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_TXDATA   = ADDR_W'(OFS_TXDATA);
  localparam logic [ADDR_W-1:0] A_BAUD     = ADDR_W'(OFS_BAUD);
  localparam int               PIN_LAST   = OFS_PIN0 + NUM_PIN - 1;

  logic wrLive;     // write while the port is on
  logic isOne;
  logic enOn, enOff;
  logic startTx, startRx, stopTx, stopRx;
  logic pinHit;

  assign wrLive = busWrEn && enabled;
  assign isOne  = (busWrData == 32'd1);
  assign pinHit = (int'(busAddr) >= OFS_PIN0) && (int'(busAddr) <= PIN_LAST);

  always_comb begin
    strb    = '0;
    enOn    = 1'b0;
    enOff   = 1'b0;
    startTx = 1'b0;
    startRx = 1'b0;
    stopTx  = 1'b0;
    stopRx  = 1'b0;

    // The enable word is reachable even while off
    if (busWrEn && busAddr == A_ENABLE) begin
      if (busWrData == ENABLE_KEY) begin
        enOn = 1'b1;
      end else if (busWrData == '0) begin
        enOff        = 1'b1;
        stopTx       = 1'b1;
        stopRx       = 1'b1;
        strb.setRxTo = 1'b1;
      end
    end

    if (wrLive) begin
      unique case (busAddr)
        A_STARTRX:  startRx = isOne;
        A_STARTTX:  startTx = isOne;
        A_STOPTX:   stopTx  = isOne;
        A_STOPRX: begin
          stopRx       = isOne;
          strb.setRxTo = isOne;
        end
        A_SUSPEND: begin
          stopTx       = isOne;
          stopRx       = isOne;
          strb.setRxTo = isOne;
        end
        A_EV_RXRDY: strb.wrEvRx    = 1'b1;
        A_EV_TXRDY: strb.wrEvTx    = 1'b1;
        A_EV_ERR:   strb.wrEvErr   = 1'b1;
        A_EV_RXTO:  strb.wrEvTo    = 1'b1;
        A_MASK:     strb.wrMask    = 1'b1;
        A_MASKSET:  strb.wrMaskSet = 1'b1;
        A_MASKCLR:  strb.wrMaskClr = 1'b1;
        A_ERRSRC:   strb.wrErrSrc  = 1'b1;
        A_TXDATA:   strb.wrTxData  = txStarted && !txPending;
        A_BAUD:     strb.wrBaud    = 1'b1;
        default:    strb.wrPin     = pinHit;
      endcase
    end

    strb.txFinish = txDone && txPending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enabled   <= 1'b0;
      txStarted <= 1'b0;
      rxStarted <= 1'b0;
      txPending <= 1'b0;
    end else begin
      if (enOn)       enabled <= 1'b1;
      else if (enOff) enabled <= 1'b0;

      if (stopTx)       txStarted <= 1'b0;
      else if (startTx) txStarted <= 1'b1;

      if (stopRx)       rxStarted <= 1'b0;
      else if (startRx) rxStarted <= 1'b1;

      if (strb.wrTxData)      txPending <= 1'b1;
      else if (strb.txFinish) txPending <= 1'b0;
    end
  end

  // R1: the key value turns the port on
  p_enable_key_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_ENABLE && busWrData == ENABLE_KEY) |=> enabled);

  // R1: other nonzero values leave the state alone
  p_enable_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_ENABLE && busWrData != ENABLE_KEY && busWrData != '0)
      |=> $stable(enabled));

  // R2: turning off halts both directions
  p_disable_halts_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_ENABLE && busWrData == '0)
      |=> (!enabled && !txStarted && !rxStarted));

  // R6: transmit starts only on a live write of exactly 1
  p_start_exact_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txStarted) |-> $past(wrLive && busAddr == A_STARTTX && busWrData == 32'd1));

  // R8: a byte becomes pending only while transmit runs
  p_pending_needs_tx_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txPending) |-> $past(txStarted));

endmodule

// File: rtl/uart_te_dp.sv
module uart_te_dp
  import uart_te_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          NUM_PIN  = 4,
  parameter int          ERRSRC_W = 4,
  parameter logic [31:0] PIN_RST  = 32'hFFFF_FFFF,
  parameter logic [31:0] BAUD_RST = 32'h0400_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  input  ctlStrobes_t       strb,
  input  logic              enabled,
  input  logic              rxReady,
  input  logic              lineBreak,
  output logic [31:0]       busRdData,
  output logic [7:0]        txByte,
  output logic              irq
);

  localparam logic [ERRSRC_W-1:0] BREAK_BITS = ERRSRC_W'(3);

  logic [MASK_W-1:0]   mask;
  logic                evRx, evTx, evErr, evTo;
  logic [ERRSRC_W-1:0] errSrc;
  logic [31:0]         baudReg;
  logic [31:0]         pinReg [NUM_PIN];
  logic [31:0]         rdMux;
  logic [31:0]         pinRd;
  logic                wrNonZero;

  assign wrNonZero = (busWrData != '0);

  // Event flags: a hardware set wins over a software write in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      evRx  <= 1'b0;
      evTx  <= 1'b0;
      evErr <= 1'b0;
      evTo  <= 1'b0;
    end else begin
      if (rxReady)                      evRx <= 1'b1;
      else if (strb.wrEvRx && !wrNonZero) evRx <= 1'b0;

      if (strb.txFinish)   evTx <= 1'b1;
      else if (strb.wrEvTx) evTx <= wrNonZero;

      if (lineBreak)         evErr <= 1'b1;
      else if (strb.wrEvErr) evErr <= wrNonZero;

      if (strb.setRxTo)     evTo <= 1'b1;
      else if (strb.wrEvTo) evTo <= wrNonZero;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mask    <= '0;
      errSrc  <= '0;
      txByte  <= '0;
      baudReg <= BAUD_RST;
    end else begin
      if (strb.wrMask)         mask <= busWrData[MASK_W-1:0];
      else if (strb.wrMaskSet) mask <= mask | busWrData[MASK_W-1:0];
      else if (strb.wrMaskClr) mask <= mask & ~busWrData[MASK_W-1:0];

      errSrc <= (errSrc & ~(strb.wrErrSrc ? busWrData[ERRSRC_W-1:0] : '0))
              | (lineBreak ? BREAK_BITS : '0);

      if (strb.wrTxData) txByte  <= busWrData[7:0];
      if (strb.wrBaud)   baudReg <= busWrData;
    end
  end

  for (genvar g = 0; g < NUM_PIN; g++) begin : gPin
    always_ff @(posedge clk) begin
      if (!rstN)
        pinReg[g] <= PIN_RST;
      else if (strb.wrPin && int'(busAddr) == OFS_PIN0 + g)
        pinReg[g] <= busWrData;
    end
  end

  always_comb begin
    pinRd = '0;
    for (int k = 0; k < NUM_PIN; k++)
      if (int'(busAddr) == OFS_PIN0 + k) pinRd = pinReg[k];
  end

  always_comb begin
    unique case (int'(busAddr))
      OFS_EV_RXRDY: rdMux = {31'd0, evRx};
      OFS_EV_TXRDY: rdMux = {31'd0, evTx};
      OFS_EV_ERR:   rdMux = {31'd0, evErr};
      OFS_EV_RXTO:  rdMux = {31'd0, evTo};
      OFS_MASK,
      OFS_MASKSET,
      OFS_MASKCLR:  rdMux = 32'(mask);
      OFS_ERRSRC:   rdMux = 32'(errSrc);
      OFS_ENABLE:   rdMux = ENABLE_KEY;
      OFS_TXDATA:   rdMux = {24'd0, txByte};
      OFS_BAUD:     rdMux = baudReg;
      default:      rdMux = pinRd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      busRdData <= '0;
    else
      busRdData <= (busRdEn && enabled) ? rdMux : '0;
  end

  assign irq = (evRx  && mask[MB_RXRDY]) || (evTx && mask[MB_TXRDY])
            || (evErr && mask[MB_ERR])   || (evTo && mask[MB_RXTO]);

  // R3: nothing leaks out while the port is off
  p_off_reads_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !enabled) |=> (busRdData == '0));

  // R4: bits written to the set alias end up in the mask
  p_mask_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMaskSet |=> ((mask & $past(busWrData[MASK_W-1:0])) == $past(busWrData[MASK_W-1:0])));

  // R9: a line break latches the error source and the error event
  p_break_latch_r9: assert property (@(posedge clk) disable iff (!rstN)
    lineBreak |=> (evErr && errSrc[1:0] == 2'b11));

  // R10: receive-ready survives anything but its own clearing write
  p_rxrdy_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (evRx && !strb.wrEvRx) |=> evRx);

endmodule

// File: rtl/uart_te_top.sv
module uart_te_top
  import uart_te_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          NUM_PIN  = 4,
  parameter int          ERRSRC_W = 4,
  parameter logic [31:0] PIN_RST  = 32'hFFFF_FFFF,
  parameter logic [31:0] BAUD_RST = 32'h0400_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  output logic [7:0]        txByte,
  output logic              txValid,
  input  logic              txDone,
  output logic              txStarted,
  output logic              rxStarted,
  input  logic              rxReady,
  input  logic              lineBreak,
  output logic              irq
);

  ctlStrobes_t strb;
  logic        enabled;

  uart_te_ctrl #(.ADDR_W(ADDR_W), .NUM_PIN(NUM_PIN)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .txDone    (txDone),
    .strb      (strb),
    .enabled   (enabled),
    .txStarted (txStarted),
    .rxStarted (rxStarted),
    .txPending (txValid)
  );

  uart_te_dp #(
    .ADDR_W(ADDR_W), .NUM_PIN(NUM_PIN), .ERRSRC_W(ERRSRC_W),
    .PIN_RST(PIN_RST), .BAUD_RST(BAUD_RST)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdEn   (busRdEn),
    .strb      (strb),
    .enabled   (enabled),
    .rxReady   (rxReady),
    .lineBreak (lineBreak),
    .busRdData (busRdData),
    .txByte    (txByte),
    .irq       (irq)
  );

endmodule

// File: tb/tb_uart_te_top.sv
module tb_uart_te_top;
  import uart_te_pkg::*;

  localparam int ADDR_W  = 6;
  localparam int NUM_PIN = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [31:0]       busWrData = '0;
  logic              busRdEn = 1'b0;
  logic [31:0]       busRdData;
  logic [7:0]        txByte;
  logic              txValid;
  logic              txDone = 1'b0;
  logic              txStarted, rxStarted;
  logic              rxReady = 1'b0;
  logic              lineBreak = 1'b0;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] expQ [$];
  string       tagQ [$];
  logic        rdLatch = 1'b0;

  always #5 clk = ~clk;

  uart_te_top #(.ADDR_W(ADDR_W), .NUM_PIN(NUM_PIN)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .txByte(txByte), .txValid(txValid), .txDone(txDone),
    .txStarted(txStarted), .rxStarted(rxStarted), .rxReady(rxReady),
    .lineBreak(lineBreak), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    busAddr = ADDR_W'(a); busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  // Driver: push the expected word, then issue the read
  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp); tagQ.push_back(tag);
    busAddr = ADDR_W'(a); busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic pulseRx();
    @(negedge clk); rxReady = 1'b1; @(negedge clk); rxReady = 1'b0;
  endtask
  task automatic pulseDone();
    @(negedge clk); txDone = 1'b1; @(negedge clk); txDone = 1'b0;
  endtask
  task automatic pulseBreak();
    @(negedge clk); lineBreak = 1'b1; @(negedge clk); lineBreak = 1'b0;
  endtask

  // Monitor: read data is valid in the cycle after the request
  always @(posedge clk) rdLatch <= busRdEn;
  always @(negedge clk) begin
    if (rdLatch) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12: actual unexpected read 0x%0h expected none", busRdData);
      end else begin
        chk(busRdData, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // Reset state
    chk(irq, 0, "R11 irq after reset");
    chk(txValid, 0, "R11 txValid after reset");
    chk(txStarted, 0, "R11 txStarted after reset");
    chk(rxStarted, 0, "R11 rxStarted after reset");
    rd(OFS_BAUD, 0, "R3 read while off");

    // Enable key
    wr(OFS_ENABLE, 5);
    rd(OFS_BAUD, 0, "R1 wrong key keeps port off");
    wr(OFS_ENABLE, 4);
    rd(OFS_BAUD, 32'h0400_0000, "R11 baud reset");
    for (int p = 0; p < NUM_PIN; p++) rd(OFS_PIN0 + p, 32'hFFFF_FFFF, "R11 pin reset");
    rd(OFS_MASK, 0, "R11 mask reset");
    rd(OFS_ERRSRC, 0, "R11 error source reset");
    rd(OFS_EV_RXTO, 0, "R11 event reset");
    rd(OFS_ENABLE, 4, "R1 enable readback");
    rd(63, 0, "R12 unmapped read");
    rd(OFS_STARTTX, 0, "R12 task word read");
    wr(OFS_PIN0 + 2, 32'h1234_5678);
    rd(OFS_PIN0 + 2, 32'h1234_5678, "R11 pin storage");

    // Start tasks
    wr(OFS_STARTTX, 2);
    chk(txStarted, 0, "R6 start with value 2");
    wr(OFS_STARTTX, 1);
    chk(txStarted, 1, "R6 start transmit");
    wr(OFS_STARTRX, 1);
    chk(rxStarted, 1, "R6 start receive");

    // Transmit hand-off
    wr(OFS_TXDATA, 32'hA5);
    chk(txValid, 1, "R8 byte accepted");
    chk(txByte, 8'hA5, "R8 byte value");
    wr(OFS_TXDATA, 32'h3C);
    chk(txByte, 8'hA5, "R8 write while pending ignored");
    pulseDone();
    chk(txValid, 0, "R8 done clears pending");
    rd(OFS_EV_TXRDY, 1, "R8 transmit-ready event");
    wr(OFS_TXDATA, 32'h5A);
    chk(txByte, 8'h5A, "R8 second byte");
    pulseDone();

    // Mask aliases
    wr(OFS_MASK, 1);
    wr(OFS_MASKSET, 6);
    rd(OFS_MASKSET, 7, "R4 read via set alias");
    rd(OFS_MASKCLR, 7, "R4 read via clear alias");
    wr(OFS_MASKCLR, 2);
    rd(OFS_MASK, 5, "R4 clear alias");

    // Interrupt
    chk(irq, 0, "R5 masked event");
    wr(OFS_MASKSET, 2);
    chk(irq, 1, "R5 unmasked transmit-ready");
    wr(OFS_EV_TXRDY, 0);
    chk(irq, 0, "R5 event cleared");

    // Receive-ready
    pulseRx();
    rd(OFS_EV_RXRDY, 1, "R10 rxReady sets event");
    chk(irq, 1, "R5 receive-ready irq");
    wr(OFS_EV_RXRDY, 5);
    rd(OFS_EV_RXRDY, 1, "R10 nonzero write ignored");
    wr(OFS_EV_RXRDY, 0);
    rd(OFS_EV_RXRDY, 0, "R10 zero write clears");
    chk(irq, 0, "R5 irq drops");
    wr(OFS_EV_ERR, 7);
    rd(OFS_EV_ERR, 1, "R10 nonzero write sets");
    wr(OFS_EV_ERR, 0);
    rd(OFS_EV_ERR, 0, "R10 zero write clears error");

    // Line break and error source
    pulseBreak();
    rd(OFS_ERRSRC, 3, "R9 break bits");
    rd(OFS_EV_ERR, 1, "R9 error event");
    wr(OFS_ERRSRC, 1);
    rd(OFS_ERRSRC, 2, "R9 write-one-to-clear bit 0");
    wr(OFS_ERRSRC, 2);
    rd(OFS_ERRSRC, 0, "R9 write-one-to-clear bit 1");
    wr(OFS_EV_ERR, 0);

    // Stop and suspend
    wr(OFS_STOPTX, 1);
    chk(txStarted, 0, "R7 stop transmit");
    chk(rxStarted, 1, "R7 stop transmit keeps receive");
    rd(OFS_EV_RXTO, 0, "R7 stop transmit no timeout");
    wr(OFS_STOPRX, 1);
    chk(rxStarted, 0, "R7 stop receive");
    rd(OFS_EV_RXTO, 1, "R7 stop receive sets timeout");
    wr(OFS_EV_RXTO, 0);
    wr(OFS_STARTTX, 1);
    wr(OFS_STARTRX, 1);
    wr(OFS_SUSPEND, 2);
    chk(txStarted, 1, "R7 suspend value 2 ignored");
    wr(OFS_SUSPEND, 1);
    chk(txStarted, 0, "R7 suspend halts transmit");
    chk(rxStarted, 0, "R7 suspend halts receive");
    rd(OFS_EV_RXTO, 1, "R7 suspend sets timeout");
    wr(OFS_MASKSET, 8);
    chk(irq, 1, "R5 timeout irq");
    wr(OFS_MASKCLR, 8);
    chk(irq, 0, "R5 timeout masked");

    // Disable acts as suspend
    wr(OFS_EV_RXTO, 0);
    wr(OFS_STARTTX, 1);
    wr(OFS_STARTRX, 1);
    wr(OFS_ENABLE, 0);
    chk(txStarted, 0, "R2 disable halts transmit");
    chk(rxStarted, 0, "R2 disable halts receive");
    rd(OFS_BAUD, 0, "R3 read while off");
    wr(OFS_MASKSET, 32'hF);
    wr(OFS_STARTTX, 1);
    chk(txStarted, 0, "R3 task ignored while off");
    wr(OFS_ENABLE, 4);
    rd(OFS_EV_RXTO, 1, "R2 disable sets timeout");
    rd(OFS_MASK, 7, "R3 mask write ignored while off");
    wr(OFS_ENABLE, 7);
    rd(OFS_BAUD, 32'h0400_0000, "R1 other value keeps port on");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R12: actual %0d reads outstanding expected 0", expQ.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule